// File: doc/BRIEF.md
# Cell Header Connection-Identifier Capture

This block sits beside the byte stream that a receiver delivers, one byte per accepted transfer, in fixed 53-byte cells. As the first header bytes of a cell go by, the identifier bits are written straight into six 4-bit registers. These bits are the 8-bit path number and the 16-bit channel number. Capture happens in the same cycle the byte is accepted, so the data is not passed over a second time. The other header fields are skipped: the flow-control nibble, the payload-type and loss-priority bits, and the header checksum byte. Payload bytes are skipped as well.

Once the last identifier nibble is held, the block offers the 24-bit identifier to a connection lookup memory as two 12-bit address words. The upper half goes first and the lower half second. A select bit names which half is on the bus. After both words have been taken, the six registers keep their contents until the next cell starts. A supervisory controller can read any nibble at any time through a 3-bit index, for example to fetch the identifier of a cell that was judged invalid.

Both streams use valid/ready. On the input side, `in_ready` is high except in one case: it drops when a byte marked as cell start is offered while an address word is still outstanding. That byte then waits, and the captured identifier cannot be overwritten before the lookup has both halves. On the lookup side, a word stays on `lk_addr` with `lk_sel` unchanged until `lk_ready` is seen high with `lk_valid`.

Top module: `hdr_id_capture`

## Requirements
- R1: After reset, `lk_valid` is 0, `in_ready` is 1, `lk_sel` is 0 and every nibble read back is 0.
- R2: Identifier nibble k (k = 0..5) reads back on `rd_nib` when `rd_idx` = k, in the same cycle. The identifier is {path[7:0], channel[15:0]}, and nibble k holds identifier bits [4k+3:4k]. The header layout is: byte 0 = {flow[3:0], path[7:4]}, byte 1 = {path[3:0], channel[15:12]}, byte 2 = channel[11:4], byte 3 = {channel[3:0], type/priority[3:0]}, byte 4 = checksum.
- R3: The flow-control nibble, the type/priority nibble, the checksum byte and all payload bytes never change any identifier nibble.
- R4: One cycle after byte 3 of a cell is accepted, `lk_valid` is 1, `lk_sel` is 0 and `lk_addr` carries identifier bits [23:12].
- R5: One cycle after a transfer with `lk_sel` = 0, `lk_valid` is 1, `lk_sel` is 1 and `lk_addr` carries bits [11:0]. One cycle after the transfer with `lk_sel` = 1, `lk_valid` is 0.
- R6: While `lk_valid` is 1 and `lk_ready` is 0, `lk_valid`, `lk_addr` and `lk_sel` hold their values.
- R7: `in_ready` is 0 exactly when `in_sop` is 1 and `lk_valid` is 1. The held byte is not consumed.
- R8: The captured identifier stays unchanged from the end of its capture until a new cell-start byte is accepted.
- R9: Bytes accepted with `in_sop` = 0 after the 53rd byte of a cell, or before any cell start, are discarded.
- R10: Cycles with `in_valid` = 0 do not advance the position within the cell.
- R11: A cell-start byte accepted in the middle of a cell restarts the position count at byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte offered by the receiver |
| in_ready | output | 1 | Byte accepted this cycle when high with `in_valid` |
| in_data | input | 8 | Cell byte |
| in_sop | input | 1 | Marks the offered byte as byte 0 of a cell |
| lk_valid | output | 1 | Address word offered to the lookup |
| lk_ready | input | 1 | Lookup takes the offered word |
| lk_addr | output | 12 | Address word, upper identifier half first |
| lk_sel | output | 1 | 0 = upper half, 1 = lower half |
| rd_idx | input | 3 | Controller nibble index |
| rd_nib | output | 4 | Nibble selected by `rd_idx` |

## Verification
The results fall due at different times. A nibble becomes readable one cycle after its byte is accepted, and `rd_nib` follows `rd_idx` in the same cycle. The first address word appears one cycle after byte 3 is accepted, and each later step of the lookup sequence appears one cycle after the handshake that triggers it. `in_ready` answers `in_sop` within the same cycle. A behavioural model in the bench advances on each rising edge from the inputs present at that edge. The comparison runs shortly after each falling edge, which is exactly where each of these one-cycle or zero-cycle latencies has settled. Directed readbacks after idle periods, stray bytes, gaps, restarts and a stalled lookup tie each corner to its requirement.

// File: rtl/hic_pkg.sv
package hic_pkg;

  function automatic int bits_for(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  typedef enum logic {
    LK_IDLE = 1'b0,
    LK_SEND = 1'b1
  } lk_state_e;

endpackage

// File: rtl/hic_pos_track.sv
// Tracks the position of the byte on the input within the current cell.
module hic_pos_track
  import hic_pkg::*;
#(
  parameter int CELL_LEN = 53,
  localparam int PW = bits_for(CELL_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_acc,
  input  logic          byte_sop,
  output logic [PW-1:0] byte_pos,
  output logic          byte_in_cell
);

  localparam logic [PW-1:0] LAST_POS = PW'(CELL_LEN - 1);

  logic [PW-1:0] cnt_q;
  logic          open_q;

  // A cell-start byte is always position zero, whatever came before.
  assign byte_pos     = byte_sop ? '0 : cnt_q;
  assign byte_in_cell = byte_sop | open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      open_q <= 1'b0;
    end else if (byte_acc) begin
      if (byte_sop) begin
        cnt_q  <= PW'(1);
        open_q <= 1'b1;
      end else if (open_q) begin
        if (cnt_q == LAST_POS) begin
          cnt_q  <= '0;
          open_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R11: an accepted cell start leaves the tracker one byte into an open cell
  p_sop_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    byte_acc && byte_sop |=> byte_in_cell && (byte_pos == PW'(1) || byte_sop));

  // R10: with no accepted byte the position does not move
  p_pos_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_acc |=> $stable(cnt_q) && $stable(open_q));

endmodule

// File: rtl/hic_nib_bank.sv
// Six nibble registers written in place from the header bytes, with readback.
module hic_nib_bank
  import hic_pkg::*;
#(
  parameter int NIB_W     = 4,
  parameter int ID_NIBS   = 6,
  parameter int HDR_FIRST = 1,
  parameter int PW        = 6,
  localparam int BYTE_W    = 2 * NIB_W,
  localparam int ID_W      = NIB_W * ID_NIBS,
  localparam int IDX_W     = bits_for(ID_NIBS),
  localparam int LAST_BYTE = (HDR_FIRST + ID_NIBS - 1) / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_acc,
  input  logic              byte_in_cell,
  input  logic [PW-1:0]     byte_pos,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ID_W-1:0]   id_word,
  output logic [NIB_W-1:0]  rd_nib,
  output logic              id_done
);

  logic hdr_acc;
  assign hdr_acc = byte_acc && byte_in_cell;

  // Header nibbles are numbered in arrival order, high half of each byte first.
  // Identifier nibble k sits at header slot HDR_FIRST + ID_NIBS-1-k.
  for (genvar k = 0; k < ID_NIBS; k++) begin : g_nib
    localparam int SLOT    = HDR_FIRST + ID_NIBS - 1 - k;
    localparam int BYTE_AT = SLOT / 2;
    localparam bit HIGH    = (SLOT % 2) == 0;

    logic [NIB_W-1:0] src;
    logic [NIB_W-1:0] nib_q;

    if (HIGH) begin : g_hi
      assign src = byte_data[BYTE_W-1 -: NIB_W];
    end else begin : g_lo
      assign src = byte_data[NIB_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        nib_q <= '0;
      end else if (hdr_acc && byte_pos == PW'(BYTE_AT)) begin
        nib_q <= src;
      end
    end

    assign id_word[k*NIB_W +: NIB_W] = nib_q;
  end

  assign id_done = hdr_acc && byte_pos == PW'(LAST_BYTE);

  always_comb begin
    rd_nib = '0;
    for (int k = 0; k < ID_NIBS; k++) begin
      if (rd_idx == IDX_W'(k)) rd_nib = id_word[k*NIB_W +: NIB_W];
    end
  end

  // R3: bytes past the identifier part of the header leave the bank untouched
  p_hdr_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_acc && byte_pos > PW'(LAST_BYTE) |=> $stable(id_word));

  // R9: bytes outside any cell are discarded
  p_stray_r9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_acc && !byte_in_cell |=> $stable(id_word));

endmodule

// File: rtl/hic_word_out.sv
// Presents the identifier to the lookup as successive address words.
module hic_word_out
  import hic_pkg::*;
#(
  parameter int WORD_W    = 12,
  parameter int NUM_WORDS = 2,
  localparam int ID_W  = WORD_W * NUM_WORDS,
  localparam int SEL_W = bits_for(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_done,
  input  logic [ID_W-1:0]   id_word,
  input  logic              lk_ready,
  output logic              lk_valid,
  output logic [WORD_W-1:0] lk_addr,
  output logic [SEL_W-1:0]  lk_sel
);

  localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NUM_WORDS - 1);

  lk_state_e        st_q;
  logic [SEL_W-1:0] sel_q;
  logic [WORD_W-1:0] word_v [NUM_WORDS];

  // Word w carries the w-th slice counted from the top of the identifier.
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign word_v[w] = id_word[ID_W-1-w*WORD_W -: WORD_W];
  end

  always_comb begin
    lk_addr = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (sel_q == SEL_W'(w)) lk_addr = word_v[w];
    end
  end

  assign lk_valid = (st_q == LK_SEND);
  assign lk_sel   = sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LK_IDLE;
      sel_q <= '0;
    end else begin
      unique case (st_q)
        LK_IDLE: begin
          if (id_done) begin
            st_q  <= LK_SEND;
            sel_q <= '0;
          end
        end
        LK_SEND: begin
          if (lk_ready) begin
            if (sel_q == LAST_SEL) begin
              st_q  <= LK_IDLE;
              sel_q <= '0;
            end else begin
              sel_q <= sel_q + 1'b1;
            end
          end
        end
        default: st_q <= LK_IDLE;
      endcase
    end
  end

  // R4: completion of the identifier opens the sequence with the upper word
  p_first_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    id_done |=> lk_valid && lk_sel == '0);

  // R5: each accepted word is followed by the next one
  p_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready && lk_sel != LAST_SEL |=> lk_valid && lk_sel == $past(lk_sel) + 1'b1);

  // R5: the sequence ends after the last word is accepted
  p_finish_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready && lk_sel == LAST_SEL |=> !lk_valid);

  // R6: an offered word holds under back-pressure
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && !lk_ready |=> lk_valid && $stable(lk_sel) && $stable(lk_addr));

  // R7: a new identifier never completes while words are outstanding
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    id_done |-> !lk_valid);

endmodule

// File: rtl/hdr_id_capture.sv
module hdr_id_capture
  import hic_pkg::*;
#(
  parameter int CELL_LEN  = 53,
  parameter int NIB_W     = 4,
  parameter int ID_NIBS   = 6,
  parameter int WORD_NIBS = 3,
  parameter int HDR_FIRST = 1,
  localparam int BYTE_W    = 2 * NIB_W,
  localparam int ID_W      = NIB_W * ID_NIBS,
  localparam int NUM_WORDS = ID_NIBS / WORD_NIBS,
  localparam int WORD_W    = WORD_NIBS * NIB_W,
  localparam int SEL_W     = bits_for(NUM_WORDS),
  localparam int IDX_W     = bits_for(ID_NIBS),
  localparam int PW        = bits_for(CELL_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sop,
  output logic              lk_valid,
  input  logic              lk_ready,
  output logic [WORD_W-1:0] lk_addr,
  output logic [SEL_W-1:0]  lk_sel,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [NIB_W-1:0]  rd_nib
);

  logic          byte_acc;
  logic [PW-1:0] byte_pos;
  logic          byte_in_cell;
  logic [ID_W-1:0] id_word;
  logic          id_done;

  // A new cell may not start while the lookup still owes words.
  assign in_ready = !(lk_valid && in_sop);
  assign byte_acc = in_valid && in_ready;

  hic_pos_track #(
    .CELL_LEN(CELL_LEN)
  ) pos_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_acc    (byte_acc),
    .byte_sop    (in_sop),
    .byte_pos    (byte_pos),
    .byte_in_cell(byte_in_cell)
  );

  hic_nib_bank #(
    .NIB_W    (NIB_W),
    .ID_NIBS  (ID_NIBS),
    .HDR_FIRST(HDR_FIRST),
    .PW       (PW)
  ) bank_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_acc    (byte_acc),
    .byte_in_cell(byte_in_cell),
    .byte_pos    (byte_pos),
    .byte_data   (in_data),
    .rd_idx      (rd_idx),
    .id_word     (id_word),
    .rd_nib      (rd_nib),
    .id_done     (id_done)
  );

  hic_word_out #(
    .WORD_W   (WORD_W),
    .NUM_WORDS(NUM_WORDS)
  ) out_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .id_done (id_done),
    .id_word (id_word),
    .lk_ready(lk_ready),
    .lk_valid(lk_valid),
    .lk_addr (lk_addr),
    .lk_sel  (lk_sel)
  );

  // R7: a cell-start byte is held off while a word is outstanding
  p_sop_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && in_sop |-> !in_ready);

  // R8: the identifier is frozen while the lookup sequence runs
  p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> $stable(id_word));

endmodule

// File: tb/hdr_id_capture_tb_top.sv
`timescale 1ns/1ps
module hdr_id_capture_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_sop = 1'b0;
  logic       lk_valid;
  logic       lk_ready;
  logic [11:0] lk_addr;
  logic [0:0] lk_sel;
  logic [2:0] rd_idx = '0;
  logic [3:0] rd_nib;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int lk_mode = 0;          // 0: always ready, 1: pseudo-random, 2: never
  logic [7:0] lfsr = 8'hB7;

  always #2.5 clk = ~clk;   // 200 MHz

  hdr_id_capture dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_addr(lk_addr), .lk_sel(lk_sel), .rd_idx(rd_idx), .rd_nib(rd_nib)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // lookup-side ready pattern
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    lk_ready <= (lk_mode == 0) ? 1'b1 : (lk_mode == 1) ? lfsr[0] : 1'b0;
  end

  // ---------------- reference model ----------------
  int          m_pos = 0;
  bit          m_open = 1'b0;
  logic [23:0] m_id = '0;
  int          m_st = 0;   // 0 idle, 1 upper word offered, 2 lower word offered

  always @(posedge clk) begin
    bit rdy;
    int p;
    if (!rst_n) begin
      m_pos = 0; m_open = 1'b0; m_id = '0; m_st = 0;
    end else begin
      rdy = !(m_st != 0 && in_sop);
      if (m_st != 0 && lk_ready) m_st = (m_st == 1) ? 2 : 0;
      if (in_valid && rdy) begin
        p = in_sop ? 0 : (m_open ? m_pos : -1);
        if (p >= 0) begin
          case (p)
            0: m_id[23:20] = in_data[3:0];
            1: m_id[19:12] = in_data;
            2: m_id[11:4]  = in_data;
            3: begin m_id[3:0] = in_data[7:4]; m_st = 1; end
            default: ;
          endcase
          m_pos  = p + 1;
          m_open = (p + 1) < 53;
          if (!m_open) m_pos = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      chk("R7", "in_ready", in_ready, !(m_st != 0 && in_sop));
      chk("R4", "lk_valid", lk_valid, m_st != 0);
      if (m_st != 0) begin
        chk("R5", "lk_sel", lk_sel, m_st == 2);
        chk(m_st == 1 ? "R4" : "R5", "lk_addr", lk_addr, m_st == 1 ? m_id[23:12] : m_id[11:0]);
      end
      chk("R2", "rd_nib", rd_nib, m_id[rd_idx*4 +: 4]);
    end
  end

  // ---------------- stimulus ----------------
  task automatic put(input logic sop, input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_sop = sop; in_data = d;
    rd_idx = (rd_idx == 3'd5) ? 3'd0 : rd_idx + 3'd1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0;
    end
  endtask

  task automatic send_cell(input logic [7:0] vpi, input logic [15:0] vci, input logic [3:0] gfc,
                           input logic [3:0] pt, input bit gaps, input int nbytes);
    logic [7:0] b;
    for (int i = 0; i < nbytes; i++) begin
      case (i)
        0: b = {gfc, vpi[7:4]};
        1: b = {vpi[3:0], vci[15:12]};
        2: b = vci[11:4];
        3: b = {vci[3:0], pt};
        4: b = 8'h5A;
        default: b = 8'hFF;
      endcase
      put(i == 0, b);
      if (gaps) idle(2);
    end
    idle(1);
  endtask

  task automatic check_id(input logic [23:0] exp, input string tag);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      rd_idx = 3'(k);
      #1;
      chk(tag, "readback nibble", rd_nib, exp[k*4 +: 4]);
    end
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1", "lk_valid after reset", lk_valid, 0);
    chk("R1", "in_ready after reset", in_ready, 1);
    chk("R1", "lk_sel after reset", lk_sel, 0);
    check_id(24'h0, "R1");

    // Cell A: flow and type fields all ones must not leak into the identifier
    lk_mode = 0;
    send_cell(8'hA5, 16'h3C96, 4'hF, 4'hF, 1'b0, 53);
    idle(4);
    check_id(24'hA53C96, "R2");
    @(negedge clk); rd_idx = 3'd5; #1;
    chk("R3", "upper nibble excludes flow field", rd_nib, 4'hA);
    @(negedge clk); rd_idx = 3'd0; #1;
    chk("R3", "lowest nibble excludes type field", rd_nib, 4'h6);

    // Stray bytes with no open cell
    for (int i = 0; i < 10; i++) put(1'b0, 8'h77);
    idle(2);
    check_id(24'hA53C96, "R9");

    // Cell B with idle gaps between bytes, random lookup ready
    lk_mode = 1;
    send_cell(8'h3E, 16'h81D4, 4'h2, 4'h1, 1'b1, 53);
    idle(10);
    check_id(24'h3E81D4, "R10");

    // Abandoned cell, restarted by a new cell start
    put(1'b1, 8'h71);
    put(1'b0, 8'h12);
    send_cell(8'h5C, 16'hE07B, 4'h0, 4'h0, 1'b0, 53);
    idle(10);
    check_id(24'h5CE07B, "R11");

    // Cell D with a stalled lookup, then a cell start held off
    lk_mode = 2;
    send_cell(8'hC3, 16'h19F2, 4'h9, 4'h3, 1'b0, 53);
    @(negedge clk);
    in_valid = 1'b1; in_sop = 1'b1; in_data = 8'h0B;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      chk("R7", "cell start held off", in_ready, 0);
      chk("R6", "upper word held", lk_addr, 12'hC31);
      chk("R6", "valid held", lk_valid, 1);
    end
    check_id(24'hC319F2, "R8");
    lk_mode = 0;
    send_cell(8'hB6, 16'h4A05, 4'h7, 4'hE, 1'b0, 53);
    idle(6);
    check_id(24'hB64A05, "R8");
    @(negedge clk); #1;
    chk("R5", "sequence complete", lk_valid, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule